// File: doc/BRIEF.md
# Flash Access Protection Guard

This block sits in front of a flash controller and filters every access request before it reaches the array. Each request carries an address, a read/write flag and a flag that says whether it comes from code running on the chip or from an external programmer. Three configuration inputs set the policy:

- **Boot-region write enable.** A single bit that allows or blocks writes into the boot window.
- **Program-region protect field.** An 8-bit field whose bitwise inverse gives the number of 4 KB blocks, counted upward from the program base, that cannot be written.
- **Code-open bit.** When this bit is cleared, external programmer traffic is shut out. The one exception is a read of the device identification word.

The decision is registered. An accepted request appears on the forward outputs one cycle later, with `grant` raised in that same cycle. A refused request produces a single-cycle `err` pulse and is not forwarded. Writes issued by code running on the chip are never stopped by code protection. Only the two write-protect controls apply to them.

Top module: `flash_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `grant`, `fwd_valid` and `err` are 0. `fwd_addr`, `fwd_write` and `fwd_ext` are also 0 in that period.
- R2: The program write-protected range starts at PROG_BASE (default 0xBD00_0000) and is inclusive. It spans N blocks of 4096 bytes, where N is the bitwise inverse of `cfg_prog_lock`. The value 0xFF protects nothing, 0xFE protects up to 0xBD00_0FFF, 0xF0 up to 0xBD00_EFFF, and 0x7F up to 0xBD07_FFFF. A write anywhere in this range is refused.
- R3: When `cfg_boot_wr_en` is 0, a write to any address in [BOOT_BASE, BOOT_BASE+BOOT_SIZE) is refused. The defaults are 0xBFC0_0000 and 0x3000. When `cfg_boot_wr_en` is 1, such writes are accepted.
- R4: The write-protect rules of R2 and R3 apply to writes from both sources. Reads are never refused by these rules.
- R5: When `cfg_code_open` is 0, every request with `req_ext`=1 is refused, except a read (`req_write`=0) at ID_ADDR (default 0xBF80_F220). An external write to ID_ADDR is refused.
- R6: Requests with `req_ext`=0 are unaffected by `cfg_code_open`. An internal read is always accepted.
- R7: An accepted request gives `grant`=1 and `fwd_valid`=1 one cycle later, with `err`=0. In that cycle `fwd_addr`, `fwd_write` and `fwd_ext` carry the request's address and flags. A refused request gives `err`=1 for exactly that one cycle, with `grant` and `fwd_valid` at 0.
- R8: A cycle with `req_valid`=0 leaves `grant`, `fwd_valid` and `err` at 0 in the next cycle. Back-to-back requests are each decided independently, using the configuration present in their own cycle.
- R9: A write is accepted when it lies outside the boot window and outside the protected program range and is not blocked by R5. This includes the first address just above a protected range and any address below PROG_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | 1 = external programmer, 0 = on-chip code |
| cfg_boot_wr_en | input | 1 | 1 = boot window writable |
| cfg_prog_lock | input | LOCK_W | Inverted count of protected program blocks |
| cfg_code_open | input | 1 | 0 = code protection active |
| grant | output | 1 | Request accepted (registered pulse) |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_ext | output | 1 | Forwarded source flag |
| err | output | 1 | Request refused (registered pulse) |

## Verification
The embedded properties assume that the configuration inputs and the request fields are stable and known for the whole cycle in which `req_valid` is sampled. They also assume that `rst` is held for at least one edge before any request is made. The bench changes configuration only at the same falling edge where it presents a new request, so every request is judged against one settled configuration. The bench leaves every input untouched during reset. Address stimulus is chosen around each boundary: the last protected byte, the first unprotected byte, both edges of the boot window, and the identification word. This keeps every decision well defined rather than relying on unknown values.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  // Internal outcome of the rule check for one request.
  typedef enum logic [1:0] {
    VERDICT_PASS      = 2'd0,
    VERDICT_BOOT_LOCK = 2'd1,
    VERDICT_PROG_LOCK = 2'd2,
    VERDICT_CODE_PROT = 2'd3
  } verdict_e;

endpackage

// File: rtl/flash_guard_decode.sv
module flash_guard_decode #(
  parameter int unsigned              ADDR_W    = 32,
  parameter int unsigned              LOCK_W    = 8,
  parameter int unsigned              BLK_BYTES = 4096,
  parameter logic [ADDR_W-1:0]        PROG_BASE = 32'hBD00_0000,
  parameter logic [ADDR_W-1:0]        BOOT_BASE = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0]        BOOT_SIZE = 32'h0000_3000,
  parameter logic [ADDR_W-1:0]        ID_ADDR   = 32'hBF80_F220
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LOCK_W-1:0] prog_lock,
  output logic              hit_boot,
  output logic              hit_prog_lock,
  output logic              hit_id
);

  localparam int unsigned BLK_SHIFT = $clog2(BLK_BYTES);

  logic [ADDR_W-1:0] prog_off;
  logic [ADDR_W-1:0] blk_idx;
  logic [ADDR_W-1:0] blk_limit;
  logic [ADDR_W-1:0] boot_off;

  // Protected block count is the inverse of the field; compare block index.
  always_comb begin
    prog_off      = addr - PROG_BASE;
    blk_idx       = prog_off >> BLK_SHIFT;
    blk_limit     = {{(ADDR_W-LOCK_W){1'b0}}, ~prog_lock};
    hit_prog_lock = (addr >= PROG_BASE) && (blk_idx < blk_limit);
  end

  always_comb begin
    boot_off = addr - BOOT_BASE;
    hit_boot = (addr >= BOOT_BASE) && (boot_off < BOOT_SIZE);
  end

  assign hit_id = (addr == ID_ADDR);

endmodule

// File: rtl/flash_guard_rules.sv
module flash_guard_rules
  import flash_guard_pkg::*;
(
  input  logic     is_write,
  input  logic     is_ext,
  input  logic     hit_boot,
  input  logic     hit_prog_lock,
  input  logic     hit_id,
  input  logic     boot_wr_en,
  input  logic     code_open,
  output verdict_e verdict
);

  logic ext_blocked;

  // External traffic under code protection: only an ID read survives.
  assign ext_blocked = is_ext && !code_open && !(hit_id && !is_write);

  always_comb begin
    if (ext_blocked)
      verdict = VERDICT_CODE_PROT;
    else if (is_write && hit_boot && !boot_wr_en)
      verdict = VERDICT_BOOT_LOCK;
    else if (is_write && hit_prog_lock)
      verdict = VERDICT_PROG_LOCK;
    else
      verdict = VERDICT_PASS;
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       LOCK_W    = 8,
  parameter int unsigned       BLK_BYTES = 4096,
  parameter logic [ADDR_W-1:0] PROG_BASE = 32'hBD00_0000,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BOOT_SIZE = 32'h0000_3000,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 32'hBF80_F220
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_ext,
  input  logic              cfg_boot_wr_en,
  input  logic [LOCK_W-1:0] cfg_prog_lock,
  input  logic              cfg_code_open,
  output logic              grant,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic              fwd_ext,
  output logic              err
);

  logic     hit_boot;
  logic     hit_prog_lock;
  logic     hit_id;
  verdict_e verdict;
  logic     accept;

  flash_guard_decode #(
    .ADDR_W   (ADDR_W),
    .LOCK_W   (LOCK_W),
    .BLK_BYTES(BLK_BYTES),
    .PROG_BASE(PROG_BASE),
    .BOOT_BASE(BOOT_BASE),
    .BOOT_SIZE(BOOT_SIZE),
    .ID_ADDR  (ID_ADDR)
  ) i_decode (
    .addr         (req_addr),
    .prog_lock    (cfg_prog_lock),
    .hit_boot     (hit_boot),
    .hit_prog_lock(hit_prog_lock),
    .hit_id       (hit_id)
  );

  flash_guard_rules i_rules (
    .is_write     (req_write),
    .is_ext       (req_ext),
    .hit_boot     (hit_boot),
    .hit_prog_lock(hit_prog_lock),
    .hit_id       (hit_id),
    .boot_wr_en   (cfg_boot_wr_en),
    .code_open    (cfg_code_open),
    .verdict      (verdict)
  );

  assign accept = (verdict == VERDICT_PASS);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= 1'b0;
      fwd_valid <= 1'b0;
      err       <= 1'b0;
      fwd_addr  <= '0;
      fwd_write <= 1'b0;
      fwd_ext   <= 1'b0;
    end else begin
      grant     <= req_valid && accept;
      fwd_valid <= req_valid && accept;
      err       <= req_valid && !accept;
      if (req_valid && accept) begin
        fwd_addr  <= req_addr;
        fwd_write <= req_write;
        fwd_ext   <= req_ext;
      end
    end
  end

  // R7: forward and error never coexist
  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(fwd_valid && err));

  // R7: forwarded payload matches the request one cycle earlier
  assert_payload_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && accept) |=> (fwd_addr == $past(req_addr)) && (fwd_write == $past(req_write)));

  // R8: idle input gives quiet outputs
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!fwd_valid && !err && !grant));

  // R6: on-chip reads always go through
  assert_intread_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ext && !req_write) |=> (fwd_valid && !err));

  // R3: locked boot window refuses writes
  assert_bootlock_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && hit_boot && !cfg_boot_wr_en) |=> err);

  // R5: external writes under code protection are refused
  assert_codeprot_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ext && req_write && !cfg_code_open) |=> err);

endmodule

// File: tb/test_flash_guard.sv
`timescale 1ns/1ps
module test_flash_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_ext = 1'b0;
  logic        cfg_boot_wr_en = 1'b1;
  logic [7:0]  cfg_prog_lock = 8'hFF;
  logic        cfg_code_open = 1'b1;
  logic        grant, fwd_valid, fwd_write, fwd_ext, err;
  logic [31:0] fwd_addr;

  always #5 clk = ~clk;

  flash_guard i_flash_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_ext(req_ext), .cfg_boot_wr_en(cfg_boot_wr_en),
    .cfg_prog_lock(cfg_prog_lock), .cfg_code_open(cfg_code_open),
    .grant(grant), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_write(fwd_write), .fwd_ext(fwd_ext), .err(err)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;

  // Staged configuration, applied together with the next request.
  bit        st_boot = 1'b1;
  bit [7:0]  st_lock = 8'hFF;
  bit        st_open = 1'b1;

  // Expectation for the request presented at the previous falling edge.
  bit          has_pend = 1'b0;
  bit          exp_g, exp_e, exp_w, exp_x;
  bit [31:0]   exp_a;
  string       exp_tag;

  // Behavioural policy taken from the requirements.
  function automatic bit policy_ok(bit [31:0] a, bit w, bit x, bit boot_en,
                                   bit [7:0] lock, bit open);
    longint unsigned lo_prog = 64'hBD00_0000;
    longint unsigned hi_prog = lo_prog + longint'(8'hFF - lock) * 4096;
    bit in_prot = (a >= lo_prog) && (a < hi_prog);
    bit in_boot = (a >= 32'hBFC0_0000) && (a < 32'hBFC0_3000);
    if (x && !open && !(a == 32'hBF80_F220 && !w)) return 1'b0;
    if (w && in_boot && !boot_en) return 1'b0;
    if (w && in_prot) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_pend();
    if (!has_pend) return;
    vectors++;
    if (grant !== exp_g || fwd_valid !== exp_g || err !== exp_e ||
        (exp_g && (fwd_addr !== exp_a || fwd_write !== exp_w || fwd_ext !== exp_x))) begin
      miscompares++;
      $display("FAIL %s: grant=%b fwd=%b err=%b addr=%h w=%b x=%b | expected grant=%b err=%b addr=%h w=%b x=%b",
               exp_tag, grant, fwd_valid, err, fwd_addr, fwd_write, fwd_ext,
               exp_g, exp_e, exp_a, exp_w, exp_x);
    end
  endtask

  task automatic step(input bit v, input bit [31:0] a, input bit w, input bit x,
                      input string tag);
    bit ok;
    @(negedge clk);
    check_pend();
    cfg_boot_wr_en = st_boot;
    cfg_prog_lock  = st_lock;
    cfg_code_open  = st_open;
    req_valid = v; req_addr = a; req_write = w; req_ext = x;
    ok = policy_ok(a, w, x, st_boot, st_lock, st_open);
    exp_g = v && ok; exp_e = v && !ok;
    exp_a = a; exp_w = w; exp_x = x; exp_tag = tag;
    has_pend = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (grant !== 1'b0 || fwd_valid !== 1'b0 || err !== 1'b0 || fwd_addr !== 32'h0) begin
      miscompares++;
      $display("FAIL R1: grant=%b fwd=%b err=%b addr=%h expected all 0",
               grant, fwd_valid, err, fwd_addr);
    end
    rst = 1'b0;
    // first cycle after reset: still quiet (R1)
    exp_g = 0; exp_e = 0; exp_a = 0; exp_w = 0; exp_x = 0; exp_tag = "R1"; has_pend = 1'b1;

    // R6: internal read inside locked program range with code protection on
    st_lock = 8'h00; st_open = 1'b0;
    step(1, 32'hBD00_0000, 0, 0, "R6");
    step(1, 32'hBFC0_0010, 0, 0, "R6");
    // R6: internal write outside any lock is fine with code protection on
    st_lock = 8'hFF;
    step(1, 32'hBD00_0100, 1, 0, "R6");
    st_open = 1'b1;

    // R2 / R9: range boundaries for several field values
    st_lock = 8'hFF; step(1, 32'hBD00_0000, 1, 0, "R2");
    st_lock = 8'hFE; step(1, 32'hBD00_0FFF, 1, 0, "R2");
    step(1, 32'hBD00_1000, 1, 0, "R9");
    step(1, 32'hBD00_0000, 1, 0, "R2");
    st_lock = 8'hF0; step(1, 32'hBD00_EFFF, 1, 0, "R2");
    step(1, 32'hBD00_F000, 1, 0, "R9");
    st_lock = 8'h7F; step(1, 32'hBD07_FFFF, 1, 0, "R2");
    step(1, 32'hBD08_0000, 1, 0, "R9");
    step(1, 32'hBCFF_FFFC, 1, 0, "R9");
    step(0, 32'hBD00_0000, 1, 0, "R8");

    // R4: external writes also hit the lock; reads do not
    step(1, 32'hBD00_2000, 1, 1, "R4");
    step(1, 32'hBD00_2000, 0, 1, "R4");
    step(1, 32'hBD00_2000, 0, 0, "R4");

    // R3: boot window lock
    st_lock = 8'hFF; st_boot = 1'b0;
    step(1, 32'hBFC0_0000, 1, 0, "R3");
    step(1, 32'hBFC0_2FFC, 1, 0, "R3");
    step(1, 32'hBFC0_3000, 1, 0, "R9");
    step(1, 32'hBFBF_FFFC, 1, 0, "R9");
    step(1, 32'hBFC0_0000, 0, 0, "R4");
    st_boot = 1'b1;
    step(1, 32'hBFC0_0000, 1, 0, "R3");

    // R5: code protection toward external programmer
    st_open = 1'b0;
    step(1, 32'hBFC0_0000, 0, 1, "R5");
    step(1, 32'hBD00_0000, 1, 1, "R5");
    step(1, 32'hBF80_F220, 0, 1, "R5");
    step(1, 32'hBF80_F220, 1, 1, "R5");
    step(1, 32'hBF80_F224, 0, 1, "R5");
    step(1, 32'hBD00_0000, 1, 0, "R6");
    st_open = 1'b1;
    step(1, 32'hBFC0_0000, 0, 1, "R5");

    // R8: back-to-back with configuration switching every cycle
    for (int i = 0; i < 16; i++) begin
      st_lock = (i % 2) ? 8'hFE : 8'hFF;
      st_boot = (i % 3) != 0;
      st_open = (i % 4) != 1;
      step(1, 32'hBD00_0000 + 32'(i * 32'h800), 1, i[0], "R8");
      step(1, 32'hBFC0_0000 + 32'(i * 4), i[1], i[2], "R8");
    end
    step(0, 32'h0, 0, 0, "R8");
    step(0, 32'h0, 0, 0, "R8");
    @(negedge clk);
    check_pend();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule